// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that sits behind a simple register bus. Software selects a direction and an output value for each pin, reads back the pad levels, and configures each pin to raise an interrupt on a low level, a high level, a rising edge, a falling edge or either edge. Pending interrupts are recorded in a sticky status register, gated by a mask, and reported on three lines. One line covers the lower sixteen pins, one covers the upper sixteen, and one is their OR.

Pad inputs cross into the clock domain through a two-stage synchronizer. Edges are detected by comparing the synchronized value with its value one cycle earlier. The bus is word-addressed: `busAddr` carries the byte offset shifted right by two. Reads are combinational from the addressed register. Writes take effect at the clock edge on which `busWe` is high.

Top module: `gpio_irq_port`

## Requirements
- R1: A write to word address 0 (byte 0x00) sets the output data register. `padOut` equals that register. Reading word address 0 returns the register value, never the pad level.
- R2: A write to word address 1 (byte 0x04) sets the direction register, and `padOe` equals it (1 = pin drives). After reset, direction, output data and mask read 0, `padOe` is 0 and all interrupt lines are low.
- R3: Reading word address 2 (byte 0x08) returns `padIn` as sampled through two flops. A pad change made before clock edge k is visible after edge k+1 and not after edge k.
- R4: Each pin has a 2-bit trigger code: 00 low level, 01 high level, 10 rising edge, 11 falling edge. Pin n < 16 takes its code from bits [2n+1:2n] of word address 3 (byte 0x0C). Pin n >= 16 takes its code from bits [2(n-16)+1:2(n-16)] of word address 4 (byte 0x10). A detected condition sets the pin's status bit.
- R5: When bit n of the both-edge register (word address 7, byte 0x1C) is 1, pin n triggers on any change of its synchronized level, and its 2-bit code has no effect.
- R6: A write to the status register (word address 6, byte 0x18) clears each bit written as 1. Bits written as 0 keep their value. Status bits otherwise stay set until cleared.
- R7: When a detection and a clear hit the same status bit in the same cycle, the bit ends up set. A level-triggered bit therefore reappears at once if it is cleared while its level still holds.
- R8: `irqLow` is high when any of pins 0 to 15 has both its status bit and its mask bit (word address 5, byte 0x14) set. `irqHigh` does the same for pins 16 to 31. `irqAny` is their OR.
- R9: Output data, direction, both trigger-code words, mask and both-edge select each read back, at their own address, the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Word address of the register being accessed |
| busWe | input | 1 | Write strobe for the addressed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data from the addressed register |
| padIn | input | 32 | Raw pad levels |
| padOut | output | 32 | Output data to the pad drivers |
| padOe | output | 32 | Per-pin output enable |
| irqLow | output | 1 | Interrupt request for pins 0 to 15 |
| irqHigh | output | 1 | Interrupt request for pins 16 to 31 |
| irqAny | output | 1 | OR of the two half-port requests |

## Verification
The properties assume that `busAddr`, `busWe` and `busWdata` are stable around the sampling edge, and that `padIn` is held at a fixed value until the synchronizer has settled. Only then do the clear and set-priority checks relate one write to one detection cycle. The stimulus changes every bus signal and pad value on the falling clock edge. After each pad change it waits four cycles before reading or clearing status, so every edge detection has finished before the next action. Each trigger configuration, including the mixed per-pin codes and the both-edge overrides, is swept over the same pad sequence, and the expected status is computed arithmetically from the codes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    SEL_DOUT  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_PAD   = 3'd2,
    SEL_CFGLO = 3'd3,
    SEL_CFGHI = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_BOTH  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDout;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrStat;
    logic    wrBoth;
    regSel_e rdSel;
  } ctrlStrobe_t;

  localparam logic [1:0] TRIG_LOW  = 2'b00;
  localparam logic [1:0] TRIG_HIGH = 2'b01;
  localparam logic [1:0] TRIG_RISE = 2'b10;
  localparam logic [1:0] TRIG_FALL = 2'b11;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobe_t       strobe
);
  regSel_e sel;

  assign sel = regSel_e'(busAddr[2:0]);

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = sel;
    strobe.wrDout  = busWe && (sel == SEL_DOUT);
    strobe.wrDir   = busWe && (sel == SEL_DIR);
    strobe.wrCfgLo = busWe && (sel == SEL_CFGLO);
    strobe.wrCfgHi = busWe && (sel == SEL_CFGHI);
    strobe.wrMask  = busWe && (sel == SEL_MASK);
    strobe.wrStat  = busWe && (sel == SEL_STAT);
    strobe.wrBoth  = busWe && (sel == SEL_BOTH);
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] statQ,
  output logic [NUM_PINS-1:0] maskQ,
  output logic [NUM_PINS-1:0] hitV,
  output logic                irqLo,
  output logic                irqHi
);
  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] doutR, dirR, cfgLoR, cfgHiR, maskR, statR, bothR;
  logic [NUM_PINS-1:0] padSync, padPrev, pend;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (padIn),
    .q    (padSync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doutR   <= '0;
      dirR    <= '0;
      cfgLoR  <= '0;
      cfgHiR  <= '0;
      maskR   <= '0;
      bothR   <= '0;
      padPrev <= '0;
    end else begin
      padPrev <= padSync;
      if (strobe.wrDout)  doutR  <= busWdata;
      if (strobe.wrDir)   dirR   <= busWdata;
      if (strobe.wrCfgLo) cfgLoR <= busWdata;
      if (strobe.wrCfgHi) cfgHiR <= busWdata;
      if (strobe.wrMask)  maskR  <= busWdata;
      if (strobe.wrBoth)  bothR  <= busWdata;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [1:0] code;
    logic       cur, prv;
    if (g < HALF) begin : g_lo
      assign code = cfgLoR[2*g +: 2];
    end else begin : g_hi
      assign code = cfgHiR[2*(g-HALF) +: 2];
    end
    assign cur = padSync[g];
    assign prv = padPrev[g];
    always_comb begin
      if (bothR[g]) begin
        hitV[g] = cur ^ prv;
      end else begin
        case (code)
          TRIG_LOW:  hitV[g] = ~cur;
          TRIG_HIGH: hitV[g] = cur;
          TRIG_RISE: hitV[g] = cur & ~prv;
          default:   hitV[g] = ~cur & prv;
        endcase
      end
    end
  end

  // Detection wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n) statR <= '0;
    else        statR <= (statR & ~(strobe.wrStat ? busWdata : '0)) | hitV;
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_DOUT:  busRdata = doutR;
      SEL_DIR:   busRdata = dirR;
      SEL_PAD:   busRdata = padSync;
      SEL_CFGLO: busRdata = cfgLoR;
      SEL_CFGHI: busRdata = cfgHiR;
      SEL_MASK:  busRdata = maskR;
      SEL_STAT:  busRdata = statR;
      default:   busRdata = bothR;
    endcase
  end

  assign pend   = statR & maskR;
  assign irqLo  = |pend[HALF-1:0];
  assign irqHi  = |pend[NUM_PINS-1:HALF];
  assign padOut = doutR;
  assign padOe  = dirR;
  assign statQ  = statR;
  assign maskQ  = maskR;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh,
  output logic                irqAny
);
  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] statQ, maskQ, hitV;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .statQ   (statQ),
    .maskQ   (maskQ),
    .hitV    (hitV),
    .irqLo   (irqLow),
    .irqHi   (irqHigh)
  );

  assign irqAny = irqLow | irqHigh;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [NUM_PINS-1:0] busWdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] statQ,
  input logic [NUM_PINS-1:0] maskQ,
  input logic [NUM_PINS-1:0] hitV,
  input logic                irqAny
);
  p_dout_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == 3'd0) |=> (padOut == $past(busWdata)));

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == 3'd1) |=> (padOe == $past(busWdata)));

  p_clear_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == 3'd6 && hitV == '0) |=> ((statQ & $past(busWdata)) == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hitV) |=> ((statQ & $past(hitV)) == $past(hitV)));

  p_mask_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ == '0) |-> !irqAny);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busWdata(busWdata),
  .padOut  (padOut),
  .padOe   (padOe),
  .statQ   (statQ),
  .maskQ   (maskQ),
  .hitV    (hitV),
  .irqAny  (irqAny)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  busAddr;
  logic        busWe;
  logic [31:0] busWdata, busRdata, padIn, padOut, padOe;
  logic        irqLow, irqHigh, irqAny;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [31:0] cfgLo, cfgHi, both, pads, expStat, rv;

  always #5 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqLow(irqLow), .irqHigh(irqHigh),
    .irqAny(irqAny)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] codeOf(input int n);
    return (n < 16) ? cfgLo[2*n +: 2] : cfgHi[2*(n-16) +: 2];
  endfunction

  function automatic logic [31:0] levelHits(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++)
      if (!both[n]) begin
        if (codeOf(n) == 2'b00) r[n] = ~v[n];
        if (codeOf(n) == 2'b01) r[n] = v[n];
      end
    return r;
  endfunction

  function automatic logic [31:0] edgeHits(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++) begin
      if (both[n])                 r[n] = a[n] ^ b[n];
      else if (codeOf(n) == 2'b10) r[n] = b[n] & ~a[n];
      else if (codeOf(n) == 2'b11) r[n] = a[n] & ~b[n];
    end
    return r;
  endfunction

  task automatic setPads(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
    waitc(4);
    expStat = expStat | edgeHits(pads, v) | levelHits(v);
    pads = v;
  endtask

  task automatic clearAll();
    wr(3'd6, 32'hFFFF_FFFF);
    expStat = levelHits(pads);
  endtask

  task automatic setCfg(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] b);
    wr(3'd3, lo); wr(3'd4, hi); wr(3'd7, b);
    cfgLo = lo; cfgHi = hi; both = b;
    clearAll();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; padIn = '0;
    cfgLo = '0; cfgHi = '0; both = '0; pads = '0; expStat = '0;
    waitc(3);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R2 reset state
    check("R2 reset padOe", padOe, 32'h0);
    check("R2 reset padOut", padOut, 32'h0);
    check("R2 reset irq", {29'd0, irqLow, irqHigh, irqAny}, 32'h0);
    rd(3'd1, rv); check("R2 reset dir", rv, 32'h0);
    rd(3'd5, rv); check("R2 reset mask", rv, 32'h0);
    rd(3'd0, rv); check("R2 reset dout", rv, 32'h0);

    // R1 output data, not pad level
    wr(3'd0, 32'hA5A5_3C3C);
    @(negedge clk) padIn = 32'h0000_FFFF;
    waitc(4);
    rd(3'd0, rv); check("R1 dout readback", rv, 32'hA5A5_3C3C);
    check("R1 padOut", padOut, 32'hA5A5_3C3C);
    @(negedge clk) padIn = 32'h0;
    waitc(4);

    // R2 direction
    wr(3'd1, 32'hF00F_1234);
    check("R2 padOe", padOe, 32'hF00F_1234);

    // R3 two-flop latency
    @(negedge clk);
    busAddr = 3'd2; padIn = 32'h9876_5432;
    @(posedge clk); #1;
    check("R3 pad after one edge", busRdata, 32'h0);
    @(posedge clk); #1;
    check("R3 pad after two edges", busRdata, 32'h9876_5432);
    pads = 32'h9876_5432;
    waitc(3);

    // R4/R5 sweep over trigger configurations
    for (int c = 0; c < 7; c++) begin
      logic [31:0] lo, hi, b;
      case (c)
        0, 1, 2, 3: begin lo = {16{c[1:0]}}; hi = lo; b = 32'h0; end
        4:          begin lo = 32'hE4E4_E4E4; hi = 32'h1B1B_1B1B; b = 32'h0; end
        5:          begin lo = 32'hE4E4_E4E4; hi = 32'h1B1B_1B1B; b = 32'h5555_AAAA; end
        default:    begin lo = 32'h0; hi = 32'h5555_5555; b = 32'hFFFF_FFFF; end
      endcase
      setCfg(lo, hi, b);
      rd(3'd6, rv); check((c >= 5) ? "R5 after clear" : "R4 after clear", rv, expStat);
      foreach (seqv[i]) begin
        setPads(seqv[i]);
        rd(3'd6, rv);
        check((c >= 5) ? "R5 status" : "R4 status", rv, expStat);
      end
      clearAll();
      rd(3'd6, rv); check("R7 level reappears", rv, expStat);
    end

    // R6 partial clear
    setCfg({16{2'b10}}, {16{2'b10}}, 32'h0);
    setPads(32'h0);
    clearAll();
    setPads(32'hFFFF_FFFF);
    rd(3'd6, rv); check("R6 rise all", rv, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0000_FFFF);
    rd(3'd6, rv); check("R6 partial clear", rv, 32'hFFFF_0000);
    wr(3'd6, 32'h0);
    rd(3'd6, rv); check("R6 zero write", rv, 32'hFFFF_0000);

    // R7 set wins over clear for a held high level
    setCfg({16{2'b01}}, {16{2'b01}}, 32'h0);
    setPads(32'h0010_0020);
    clearAll();
    rd(3'd6, rv); check("R7 set wins", rv, 32'h0010_0020);

    // R8 masking and split lines
    wr(3'd5, 32'h0);
    check("R8 masked off", {29'd0, irqLow, irqHigh, irqAny}, 32'h0);
    wr(3'd5, 32'h0000_0020);
    check("R8 low half", {29'd0, irqLow, irqHigh, irqAny}, 32'h5);
    wr(3'd5, 32'h0010_0000);
    check("R8 high half", {29'd0, irqLow, irqHigh, irqAny}, 32'h3);
    wr(3'd5, 32'h0000_0040);
    check("R8 unset pin", {29'd0, irqLow, irqHigh, irqAny}, 32'h0);

    // R9 register readback
    wr(3'd0, 32'h1111_2222); wr(3'd1, 32'h3333_4444); wr(3'd3, 32'h5555_6666);
    wr(3'd4, 32'h7777_8888); wr(3'd5, 32'h9999_AAAA); wr(3'd7, 32'hBBBB_CCCC);
    rd(3'd0, rv); check("R9 dout", rv, 32'h1111_2222);
    rd(3'd1, rv); check("R9 dir", rv, 32'h3333_4444);
    rd(3'd3, rv); check("R9 cfg low", rv, 32'h5555_6666);
    rd(3'd4, rv); check("R9 cfg high", rv, 32'h7777_8888);
    rd(3'd5, rv); check("R9 mask", rv, 32'h9999_AAAA);
    rd(3'd7, rv); check("R9 both", rv, 32'hBBBB_CCCC);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  logic [31:0] seqv [5] = '{32'h0F0F_3C3C, 32'h0, 32'hF0F0_C3C3, 32'h1234_5678, 32'h0};
endmodule